// File: doc/BRIEF.md
# Video memory DMA and fill engine

This block moves data into a video memory without the host writing each word itself. Software sets a transfer length, a source word address and a mode through a small register port. It then issues an access command with the DMA flag set. In copy mode the engine reads 16-bit words from a host bus and writes each one to the destination. After each write the destination moves on by a programmable increment. In fill mode the engine waits for one word on the data port. It stores that word as a normal write, then writes the word's upper byte into every following step of the run.

The length and source registers are working counters. They keep the values they reached when a run ended. A new command that reloads only part of the length therefore picks up at the next source word. While a run is active a busy flag is high. Commands and register writes are ignored until the run ends. Data-port words that arrive during a run are held and written once the run has finished.

Top module: `vdma_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `mem_we` and `hb_req` are low.
- R2: Register indices are 0x01 (bit 4 is the DMA enable), 0x0F (destination increment), 0x13 and 0x14 (length low and high bytes, in words), and 0x15, 0x16 and 0x17 (source word address bits 7:0, 15:8 and 22:16, the last taken from bits 6:0). Bits 7:6 of 0x17 select the mode: 0x means copy, 10 means fill, and 11 means a DMA command starts nothing.
- R3: `cmd_valid` while idle loads `cmd_addr` as the destination. If `cmd_dma` is set, the engine is enabled and the mode is copy or fill, `busy` is high from the next cycle.
- R4: In copy mode `hb_req` equals `mem_ready` and `hb_addr` is the source word address. Each cycle in which `hb_req` and `hb_ready` are both high writes `hb_rdata` as a word: `mem_be`=11, `mem_addr` is the destination with bit 0 cleared. That step adds the increment to the destination and adds 1 to source bits 15:0, which wrap inside their 16 bits. Bits 22:16 do not change.
- R5: A run takes as many steps as the length register holds, and a length of 0 means 65536 steps.
- R6: After a run the length register reads 0 and the source keeps its advanced value. Reloading only the length low byte and issuing a new command continues from the next source word.
- R7: In fill mode the engine waits for a data-port word. The first step writes it as a normal word. Each further step writes the upper byte to the byte address T = destination XOR 1, with `mem_wdata` = {hi,hi} and `mem_be`=10 when T is even or 01 when T is odd. The source advances on every fill step.
- R8: With the enable bit clear, a DMA command only loads the destination and `busy` stays low. A data word that follows is written normally.
- R9: A data-port word is written as a word at the destination one cycle after `data_we` (when `mem_ready` is high), and the destination then advances by the increment. A word written during a copy is written after the copy, at the address that follows the copied block.
- R10: `busy` stays high while a fill waits for its data word and falls in the cycle after the last write of the run.
- R11: While `busy` is high, register writes and commands are ignored.
- R12: When `mem_ready` is low, there is no write and no host request, and nothing advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register index |
| reg_wdata | input | 8 | Register write byte |
| cmd_valid | input | 1 | Access command strobe |
| cmd_addr | input | 16 | Destination byte address of the command |
| cmd_dma | input | 1 | Command requests a DMA run |
| data_we | input | 1 | Data-port write strobe |
| data_wdata | input | 16 | Data-port word |
| busy | output | 1 | Run in progress |
| hb_req | output | 1 | Host bus read request |
| hb_addr | output | 23 | Host bus source word address |
| hb_ready | input | 1 | Host bus read data valid |
| hb_rdata | input | 16 | Host bus read word |
| mem_we | output | 1 | Video memory write strobe |
| mem_addr | output | 16 | Video memory byte address |
| mem_be | output | 2 | Byte enables, bit 1 = even byte |
| mem_wdata | output | 16 | Video memory write data |
| mem_ready | input | 1 | Video memory can accept a write |

## Verification
The bench builds the engine with its default parameters: a 16-bit length, a 16-bit source field below a 7-bit upper field, a 16-bit destination and an 8-bit increment. With these values, wrapping the source field from 0xFFFE past zero takes only a few steps, and a zero-length fill runs the full 65536 steps well inside the cycle budget. Stalls on both memory and host bus, a data word sent during a copy, and ignored writes while busy are all compared against a behavioural model on every clock.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int DATA_W    = 16;
    localparam int REG_IDX_W = 5;

    localparam logic [REG_IDX_W-1:0] RIDX_CTRL    = 5'h01;
    localparam logic [REG_IDX_W-1:0] RIDX_STEP    = 5'h0F;
    localparam logic [REG_IDX_W-1:0] RIDX_LEN_LO  = 5'h13;
    localparam logic [REG_IDX_W-1:0] RIDX_LEN_HI  = 5'h14;
    localparam logic [REG_IDX_W-1:0] RIDX_SRC_LO  = 5'h15;
    localparam logic [REG_IDX_W-1:0] RIDX_SRC_MID = 5'h16;
    localparam logic [REG_IDX_W-1:0] RIDX_SRC_TOP = 5'h17;

    localparam int EN_BIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COPY,
        ST_FILL_WAIT,
        ST_FILL_HEAD,
        ST_FILL_TAIL
    } eng_state_t;

    typedef enum logic [1:0] {
        KIND_COPY,
        KIND_FILL,
        KIND_NONE
    } xfer_kind_t;

    typedef struct packed {
        logic              we;
        logic [1:0]        be;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    function automatic xfer_kind_t decode_kind(input logic [1:0] top2);
        if (!top2[1])
            return KIND_COPY;
        else if (!top2[0])
            return KIND_FILL;
        else
            return KIND_NONE;
    endfunction

    // byte enable for a single-byte write; bit 1 selects the even byte
    function automatic logic [1:0] lane_for(input logic odd_target);
        return odd_target ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
    import vdma_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int SRC_LO_W = 16,
    parameter int SRC_HI_W = 7,
    parameter int INC_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [REG_IDX_W-1:0]         wr_idx,
    input  logic [7:0]                   wr_data,
    input  logic                         step,
    output logic                         dma_en,
    output logic [INC_W-1:0]             inc,
    output logic                         len_last,
    output logic [SRC_LO_W+SRC_HI_W-1:0] src_addr,
    output xfer_kind_t                   kind
);
    logic [LEN_W-1:0]    len_q;
    logic [SRC_LO_W-1:0] src_lo_q;
    logic [SRC_HI_W-1:0] src_hi_q;
    logic [1:0]          kind_q;
    logic [INC_W-1:0]    inc_q;
    logic                en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q    <= '0;
            src_lo_q <= '0;
            src_hi_q <= '0;
            kind_q   <= '0;
            inc_q    <= '0;
            en_q     <= 1'b0;
        end else if (step) begin
            len_q    <= len_q - LEN_W'(1);
            src_lo_q <= src_lo_q + SRC_LO_W'(1);
        end else if (wr_en) begin
            case (wr_idx)
                RIDX_CTRL:    en_q <= wr_data[EN_BIT];
                RIDX_STEP:    inc_q <= wr_data[INC_W-1:0];
                RIDX_LEN_LO:  len_q[7:0] <= wr_data;
                RIDX_LEN_HI:  len_q[LEN_W-1:8] <= wr_data[LEN_W-9:0];
                RIDX_SRC_LO:  src_lo_q[7:0] <= wr_data;
                RIDX_SRC_MID: src_lo_q[SRC_LO_W-1:8] <= wr_data[SRC_LO_W-9:0];
                RIDX_SRC_TOP: begin
                    src_hi_q <= wr_data[SRC_HI_W-1:0];
                    kind_q   <= wr_data[7:6];
                end
                default: ;
            endcase
        end
    end

    assign dma_en   = en_q;
    assign inc      = inc_q;
    assign len_last = (len_q == LEN_W'(1));
    assign src_addr = {src_hi_q, src_lo_q};
    assign kind     = decode_kind(kind_q);

    AST_SRC_TOP_HELD: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(src_hi_q)) else $error("source top field moved"); // R4

    AST_STEP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (step && wr_en) |-> 1'b0) else $error("step during register write"); // R11

endmodule

// File: rtl/vdma_dest.sv
module vdma_dest #(
    parameter int AW    = 16,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [AW-1:0]    load_addr,
    input  logic             adv,
    input  logic [INC_W-1:0] inc,
    output logic [AW-1:0]    dest
);
    logic [AW-1:0] dest_q;

    always_ff @(posedge clk) begin
        if (rst)
            dest_q <= '0;
        else if (load)
            dest_q <= load_addr;
        else if (adv)
            dest_q <= dest_q + AW'(inc);
    end

    assign dest = dest_q;

    AST_DEST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(dest_q)) else $error("destination drifted"); // R12

endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
    import vdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_dma,
    input  logic              dma_en,
    input  xfer_kind_t        kind,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              hb_ready,
    input  logic [DATA_W-1:0] hb_rdata,
    input  logic              mem_ready,
    input  logic              len_last,
    input  logic [AW-1:0]     dest,
    output logic              busy,
    output logic              hb_req,
    output wr_beat_t          beat,
    output logic [AW-1:0]     wr_addr,
    output logic              dest_load,
    output logic              dest_adv,
    output logic              step
);
    eng_state_t        st_q;
    logic              pend_v_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] fill_q;
    logic              idle;
    logic              arm;
    logic              wr_fire;
    logic [7:0]        fill_hi;

    assign idle    = (st_q == ST_IDLE);
    assign fill_hi = fill_q[DATA_W-1:DATA_W-8];

    always_comb begin
        hb_req    = 1'b0;
        beat.we   = 1'b0;
        beat.be   = 2'b11;
        beat.data = '0;
        wr_addr   = {dest[AW-1:1], 1'b0};
        case (st_q)
            ST_IDLE: begin
                if (pend_v_q && mem_ready) begin
                    beat.we   = 1'b1;
                    beat.data = pend_q;
                end
            end
            ST_COPY: begin
                hb_req = mem_ready;
                if (mem_ready && hb_ready) begin
                    beat.we   = 1'b1;
                    beat.data = hb_rdata;
                end
            end
            ST_FILL_HEAD: begin
                if (mem_ready) begin
                    beat.we   = 1'b1;
                    beat.data = fill_q;
                end
            end
            ST_FILL_TAIL: begin
                if (mem_ready) begin
                    beat.we   = 1'b1;
                    beat.be   = lane_for(~dest[0]);
                    beat.data = {fill_hi, fill_hi};
                    wr_addr   = {dest[AW-1:1], ~dest[0]};
                end
            end
            default: ;
        endcase
    end

    assign wr_fire   = beat.we;
    assign step      = wr_fire && !idle;
    assign dest_adv  = wr_fire;
    assign dest_load = idle && cmd_valid;
    assign arm       = dest_load && cmd_dma && dma_en && (kind != KIND_NONE);
    assign busy      = !idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE:
                    if (arm)
                        st_q <= (kind == KIND_FILL) ? ST_FILL_WAIT : ST_COPY;
                ST_COPY:
                    if (step && len_last)
                        st_q <= ST_IDLE;
                ST_FILL_WAIT:
                    if (data_we)
                        st_q <= ST_FILL_HEAD;
                ST_FILL_HEAD, ST_FILL_TAIL:
                    if (step)
                        st_q <= len_last ? ST_IDLE : ST_FILL_TAIL;
                default:
                    st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v_q <= 1'b0;
            pend_q   <= '0;
            fill_q   <= '0;
        end else begin
            if (st_q == ST_FILL_WAIT) begin
                if (data_we)
                    fill_q <= data_wdata;
            end else if (data_we) begin
                pend_q   <= data_wdata;
                pend_v_q <= 1'b1;
            end else if (idle && wr_fire) begin
                pend_v_q <= 1'b0;
            end
        end
    end

    AST_WR_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        wr_fire |-> mem_ready) else $error("write without ready"); // R12

    AST_OFF_NO_ARM: assert property (@(posedge clk) disable iff (rst)
        (idle && cmd_valid && cmd_dma && !dma_en) |=> (st_q == ST_IDLE)) else $error("disabled engine armed"); // R8

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(wr_fire)) else $error("busy fell without final write"); // R10

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FILL_WAIT && !data_we) |=> (st_q == ST_FILL_WAIT)) else $error("fill wait left early"); // R10

endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int AW       = 16,
    parameter int LEN_W    = 16,
    parameter int SRC_LO_W = 16,
    parameter int SRC_HI_W = 7,
    parameter int INC_W    = 8,
    localparam int SRC_W   = SRC_LO_W + SRC_HI_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [7:0]           reg_wdata,
    input  logic                 cmd_valid,
    input  logic [AW-1:0]        cmd_addr,
    input  logic                 cmd_dma,
    input  logic                 data_we,
    input  logic [DATA_W-1:0]    data_wdata,
    output logic                 busy,
    output logic                 hb_req,
    output logic [SRC_W-1:0]     hb_addr,
    input  logic                 hb_ready,
    input  logic [DATA_W-1:0]    hb_rdata,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [1:0]           mem_be,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_ready
);
    logic             dma_en;
    logic [INC_W-1:0] inc;
    logic             len_last;
    xfer_kind_t       kind;
    logic [AW-1:0]    dest;
    logic             dest_load;
    logic             dest_adv;
    logic             step;
    wr_beat_t         beat;
    logic [AW-1:0]    wr_addr;

    vdma_regs #(
        .LEN_W(LEN_W), .SRC_LO_W(SRC_LO_W), .SRC_HI_W(SRC_HI_W), .INC_W(INC_W)
    ) regs_i (
        .clk(clk), .rst(rst),
        .wr_en(reg_we && !busy), .wr_idx(reg_idx), .wr_data(reg_wdata),
        .step(step), .dma_en(dma_en), .inc(inc), .len_last(len_last),
        .src_addr(hb_addr), .kind(kind)
    );

    vdma_dest #(.AW(AW), .INC_W(INC_W)) dest_i (
        .clk(clk), .rst(rst),
        .load(dest_load), .load_addr(cmd_addr),
        .adv(dest_adv), .inc(inc), .dest(dest)
    );

    vdma_ctrl #(.AW(AW)) ctrl_i (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .dma_en(dma_en), .kind(kind),
        .data_we(data_we), .data_wdata(data_wdata),
        .hb_ready(hb_ready), .hb_rdata(hb_rdata), .mem_ready(mem_ready),
        .len_last(len_last), .dest(dest),
        .busy(busy), .hb_req(hb_req), .beat(beat), .wr_addr(wr_addr),
        .dest_load(dest_load), .dest_adv(dest_adv), .step(step)
    );

    assign mem_we    = beat.we;
    assign mem_be    = beat.be;
    assign mem_wdata = beat.data;
    assign mem_addr  = wr_addr;

    AST_FILL_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_be != 2'b11) |-> ($onehot(mem_be) && mem_wdata[15:8] == mem_wdata[7:0])) else $error("bad fill lane"); // R7

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        hb_req |-> busy) else $error("host request while idle"); // R4

endmodule

// File: tb/vdma_engine_tb_top.sv
module vdma_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic        cmd_dma = 1'b0;
    logic        data_we = 1'b0;
    logic [15:0] data_wdata = '0;
    logic        busy;
    logic        hb_req;
    logic [22:0] hb_addr;
    logic        hb_ready = 1'b1;
    logic [15:0] hb_rdata;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic        mem_ready = 1'b1;

    always #4 clk = ~clk;

    assign hb_rdata = hb_addr[15:0] ^ 16'h5A3C;

    vdma_engine dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_dma(cmd_dma),
        .data_we(data_we), .data_wdata(data_wdata), .busy(busy),
        .hb_req(hb_req), .hb_addr(hb_addr), .hb_ready(hb_ready), .hb_rdata(hb_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state: 0 idle, 1 copy, 2 fill wait, 3 fill head, 4 fill tail
    int m_st, m_dest, m_inc, m_len, m_srclo, m_srchi, m_kind2, m_en, m_pv, m_pd, m_fd;
    int wr_count = 0, last_addr = 0, last_be = 0, last_data = 0;
    int cyc = 0;
    bit stall_on = 0, hb_toggle = 0;

    bit e_we, e_hb;
    int e_addr, e_be, e_data;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    always_comb begin
        e_we = 1'b0; e_hb = 1'b0;
        e_addr = m_dest & 'hFFFE; e_be = 3; e_data = 0;
        case (m_st)
            0: if (m_pv != 0 && mem_ready) begin e_we = 1'b1; e_data = m_pd; end
            1: begin
                e_hb = mem_ready;
                if (mem_ready && hb_ready) begin e_we = 1'b1; e_data = m_srclo ^ 'h5A3C; end
            end
            3: if (mem_ready) begin e_we = 1'b1; e_data = m_fd; end
            4: if (mem_ready) begin
                e_we = 1'b1;
                e_addr = m_dest ^ 1;
                e_be = ((m_dest ^ 1) & 1) != 0 ? 1 : 2;
                e_data = ((m_fd >> 8) & 255) * 257;
            end
            default: ;
        endcase
    end

    always @(posedge clk) begin
        bit last;
        if (rst) begin
            m_st = 0; m_dest = 0; m_inc = 0; m_len = 0; m_srclo = 0; m_srchi = 0;
            m_kind2 = 0; m_en = 0; m_pv = 0; m_pd = 0; m_fd = 0;
        end else begin
            last = (m_len == 1);
            if (e_we) begin
                wr_count++; last_addr = e_addr; last_be = e_be; last_data = e_data;
            end
            case (m_st)
                0: begin
                    if (e_we) begin m_dest = (m_dest + m_inc) & 'hFFFF; m_pv = 0; end
                    if (data_we) begin m_pd = int'(data_wdata); m_pv = 1; end
                    if (cmd_valid) begin
                        m_dest = int'(cmd_addr);
                        if (cmd_dma && m_en != 0 && m_kind2 != 3)
                            m_st = (m_kind2 == 2) ? 2 : 1;
                    end
                    if (reg_we) begin
                        case (reg_idx)
                            5'h01: m_en = (int'(reg_wdata) >> 4) & 1;
                            5'h0F: m_inc = int'(reg_wdata);
                            5'h13: m_len = (m_len & 'hFF00) | int'(reg_wdata);
                            5'h14: m_len = (m_len & 'hFF) | (int'(reg_wdata) << 8);
                            5'h15: m_srclo = (m_srclo & 'hFF00) | int'(reg_wdata);
                            5'h16: m_srclo = (m_srclo & 'hFF) | (int'(reg_wdata) << 8);
                            5'h17: begin m_srchi = int'(reg_wdata) & 'h7F; m_kind2 = int'(reg_wdata) >> 6; end
                            default: ;
                        endcase
                    end
                end
                2: if (data_we) begin m_fd = int'(data_wdata); m_st = 3; end
                default: begin
                    if (data_we) begin m_pd = int'(data_wdata); m_pv = 1; end
                    if (e_we) begin
                        m_dest = (m_dest + m_inc) & 'hFFFF;
                        m_srclo = (m_srclo + 1) & 'hFFFF;
                        m_len = (m_len - 1) & 'hFFFF;
                        if (m_st == 1) m_st = last ? 0 : 1;
                        else m_st = last ? 0 : 4;
                    end
                end
            endcase
        end
    end

    function automatic string mem_tag(input int st);
        if (st == 0) return "R9";
        if (st == 1) return "R4";
        return "R7";
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            check(busy == (m_st != 0), "R10 busy", int'(busy), int'(m_st != 0));
            check(hb_req == e_hb, "R4 hb_req", int'(hb_req), int'(e_hb));
            if (e_hb) check(int'(hb_addr) == m_srchi * 65536 + m_srclo, "R4 hb_addr", int'(hb_addr), m_srchi * 65536 + m_srclo);
            check(mem_we == e_we, mem_tag(m_st), int'(mem_we), int'(e_we));
            if (e_we && mem_we) begin
                check(int'(mem_addr) == e_addr, mem_tag(m_st), int'(mem_addr), e_addr);
                check(int'(mem_be) == e_be, mem_tag(m_st), int'(mem_be), e_be);
                check(int'(mem_wdata) == e_data, mem_tag(m_st), int'(mem_wdata), e_data);
            end
            if (!mem_ready) check(!mem_we && !hb_req, "R12 stall", int'({mem_we, hb_req}), 0);
        end
    end

    always @(posedge clk) begin
        #1;
        cyc++;
        mem_ready = !(stall_on && (cyc % 3 == 0));
        hb_ready  = !(hb_toggle && (cyc % 2 == 0));
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wreg(input logic [4:0] idx, input logic [7:0] val);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic cmd(input logic [15:0] a, input bit dma);
        cmd_valid = 1'b1; cmd_addr = a; cmd_dma = dma;
        tick(1);
        cmd_valid = 1'b0; cmd_dma = 1'b0;
    endtask

    task automatic dwr(input logic [15:0] d);
        data_we = 1'b1; data_wdata = d;
        tick(1);
        data_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) tick(1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int wc0;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        check(!busy && !mem_we && !hb_req, "R1 reset", int'({busy, mem_we, hb_req}), 0);

        // R9 plain data writes
        wreg(5'h0F, 8'd2);
        cmd(16'h0100, 1'b0);
        dwr(16'h1234);
        dwr(16'hABCD);
        tick(2);
        check(last_addr == 'h102 && last_data == 'hABCD, "R9 plain", last_addr, 'h102);

        // R8 disabled engine
        wreg(5'h13, 8'd3);
        wreg(5'h17, 8'h80);
        cmd(16'h0080, 1'b1);
        check(!busy, "R8 no busy", int'(busy), 0);
        dwr(16'h5555);
        tick(2);
        check(last_addr == 'h80 && last_data == 'h5555, "R8 normal write", last_data, 'h5555);

        // R2 R3 R4 copy with stalls, source wrap
        wreg(5'h01, 8'h10);
        wreg(5'h13, 8'd8);
        wreg(5'h14, 8'd0);
        wreg(5'h15, 8'hFE);
        wreg(5'h16, 8'hFF);
        wreg(5'h17, 8'h12);
        stall_on = 1; hb_toggle = 1;
        cmd(16'h0200, 1'b1);
        check(busy, "R3 busy", int'(busy), 1);
        check(int'(hb_addr) == 'h12FFFE, "R2 source", int'(hb_addr), 'h12FFFE);
        dwr(16'h7777);
        wreg(5'h15, 8'h40);
        cmd(16'h0400, 1'b1);
        wait_idle();
        tick(4);
        check(last_addr == 'h210 && last_data == 'h7777, "R9 after copy", last_addr, 'h210);

        // R6 R11 continuation from advanced source
        stall_on = 0; hb_toggle = 0;
        tick(1);
        wreg(5'h13, 8'd2);
        cmd(16'h0300, 1'b1);
        check(int'(hb_addr) == 'h120006, "R6 R11 continue", int'(hb_addr), 'h120006);
        wait_idle();
        tick(1);

        // R7 R10 fill of three steps at odd address
        wreg(5'h0F, 8'd3);
        wreg(5'h13, 8'd3);
        wreg(5'h17, 8'h80);
        cmd(16'h0101, 1'b1);
        tick(4);
        check(busy, "R10 fill wait", int'(busy), 1);
        wc0 = wr_count;
        dwr(16'h1122);
        wait_idle();
        check(wr_count - wc0 == 3, "R7 fill count", wr_count - wc0, 3);
        check(last_addr == 'h106 && last_be == 2, "R7 fill lane", last_addr, 'h106);

        // R2 mode 11 starts nothing
        wreg(5'h17, 8'hC0);
        wreg(5'h13, 8'd1);
        cmd(16'h0000, 1'b1);
        check(!busy, "R2 mode none", int'(busy), 0);

        // R5 zero length fill is 65536 steps
        wreg(5'h0F, 8'd2);
        wreg(5'h13, 8'd0);
        wreg(5'h14, 8'd0);
        wreg(5'h17, 8'h80);
        cmd(16'h0000, 1'b1);
        wc0 = wr_count;
        dwr(16'hBEEF);
        wait_idle();
        check(wr_count - wc0 == 65536, "R5 zero length", wr_count - wc0, 65536);

        tick(2);
        summary();
        $finish;
    end

endmodule